// File: doc/BRIEF.md
# Serial Port Register Bank with Loopback

This block is the byte-wide register file of a classic PC-style serial port. A processor bus reaches eight byte registers through a 3-bit offset, with one read or one write per cycle. The bank holds the line and modem settings, a scratch byte and a 16-bit baud divisor. It also keeps a receive queue that an outside byte source fills. Bytes written for transmission leave on a one-cycle valid/data strobe. Interrupt sources are tracked in an identification register, and each signalling event produces a one-cycle pulse on a single interrupt line.

Setting the loopback bit in modem control sends transmitted bytes into the receive queue instead, up to the queue depth. Bytes from the outside source are dropped while loopback is on. In loopback, the modem status read shows the modem control outputs in place of the input lines. Bit timing, baud generation and FIFO control are not part of this block.

Read data is combinational from the current state. The side effects of a read (popping the queue, clearing interrupt sources) take effect at the clock edge that ends the access. Within one cycle the bus access is applied first and an outside push second.

Top module: `serial_reg_bank`

## Requirements
- R1: After reset, the reads return: offset 2 = 0xC1, offset 3 = 0x03, offset 4 = 0x08, offset 5 = 0x60, offset 6 = 0xB0, offset 7 = 0x00, offset 1 = 0x00, and offset 0 = 0x00 (empty queue). The divisor resets to 12.
- R2: Offset 7 is a read/write scratch byte and offset 3 is line control. While line-control bit 7 is set, offsets 0 and 1 read and write the low and high divisor bytes, and the queue and the enable register are left untouched.
- R3: A write to offset 1 (with line-control bit 7 clear) stores only bits 3:0 as the interrupt enable. Reads return them with the upper nibble zero.
- R4: Outside loopback, a write to offset 0 drives tx_valid high with tx_data equal to the byte during the next cycle. If enable bit 1 is set, it also adds the transmit-empty source (identification value 0x02) and pulses irq.
- R5: An enable write whose bits 3:0 differ from the stored value adds transmit-empty when new bit 1 is set. An enable write with new bit 0 set while data is pending adds the receive source (0x04), unless that source is already set.
- R6: A read of offset 2 returns the identification value OR 0xC0 and then resets it to 0x01. Bit 0 is 1 exactly when no source (0x02, 0x04) is set.
- R7: irq is a registered one-cycle pulse, one cycle after an event that adds a source. A receive event signals only when enable bit 0 is set and the receive source is not already set.
- R8: A read of offset 0 returns the queue head in arrival order, or 0 when the queue is empty. It removes the receive source, and line-status bit 0 clears when the queue held at most one byte.
- R9: Outside loopback, an outside byte (src_valid) is queued and sets line-status bit 0. It is dropped when the queue already holds QDEPTH bytes, and also dropped whenever loopback (modem-control bit 4) is on.
- R10: In loopback, a write to offset 0 produces no tx_valid. It queues the byte only while fewer than QDEPTH (64) bytes are held, and may raise the receive interrupt.
- R11: In loopback, offset 6 reads bits 3:0 from the stored status and maps modem-control bits 0,1,2,3 onto status bits 5,4,6,7. Outside loopback it reads 0xB0.
- R12: Writes to offsets 2, 5 and 6 change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one byte per cycle |
| rd_en | input | 1 | Bus read strobe, ignored while wr_en is high |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current offset |
| src_valid | input | 1 | Outside receive byte present |
| src_data | input | 8 | Outside receive byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that rd_en and wr_en are never high together, and that every input is low during reset. The bench drives at most one bus access per cycle, keeps all strobes low while reset is asserted, and presents outside bytes only in cycles without a bus access. Because of this, the same-cycle ordering rule is present in the design but is not exercised by the bench.

// File: rtl/serial_reg_bank.sv
module serial_reg_bank #(
  parameter int QDEPTH   = 64,
  parameter int DIV_INIT = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       src_valid,
  input  logic [7:0] src_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       irq
);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(QDEPTH);
  localparam logic [7:0] MSR_BASE = 8'hB0;

  logic [3:0]  ier, ier_n;
  logic [2:0]  iir, iir_n;
  logic [7:0]  lcr, mcr, scr;
  logic [15:0] div;
  logic        lsr0, lsr0_n, raise;
  logic [7:0]  q_mem [QDEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire dlab    = lcr[7];
  wire loop    = mcr[4];
  wire rd_go   = rd_en && !wr_en;
  wire wr_dat  = wr_en && addr == 3'd0 && !dlab;
  wire rd_dat  = rd_go && addr == 3'd0 && !dlab;
  wire do_pop  = rd_dat && cnt != '0;
  wire push_lp = wr_dat && loop && cnt != FULL;
  wire push_ex = src_valid && !loop && (cnt != FULL || do_pop);
  wire do_push = push_lp || push_ex;
  wire [7:0] push_byte = push_lp ? wdata : src_data;

  function automatic logic [2:0] add_src(input logic [2:0] v, input logic [2:0] b);
    return (v & 3'b110) | b;
  endfunction

  function automatic logic [2:0] del_src(input logic [2:0] v, input logic [2:0] b);
    logic [2:0] r;
    r = v & ~b;
    return (r == 3'b000) ? 3'b001 : r;
  endfunction

  always_comb begin
    ier_n  = ier;
    iir_n  = iir;
    lsr0_n = lsr0;
    raise  = 1'b0;
    if (wr_en && !dlab && addr == 3'd0) begin
      if (loop) begin
        if (cnt != FULL) begin
          lsr0_n = 1'b1;
          if (ier[0] && !iir_n[2]) begin iir_n = add_src(iir_n, 3'b100); raise = 1'b1; end
        end
      end else if (ier[1]) begin
        iir_n = add_src(iir_n, 3'b010);
        raise = 1'b1;
      end
    end else if (wr_en && !dlab && addr == 3'd1) begin
      ier_n = wdata[3:0];
      if (lsr0 && ier_n[0] && !iir_n[2]) begin iir_n = add_src(iir_n, 3'b100); raise = 1'b1; end
      if ((ier ^ wdata[3:0]) != 4'd0 && ier_n[1]) begin iir_n = add_src(iir_n, 3'b010); raise = 1'b1; end
    end else if (rd_dat) begin
      iir_n = del_src(iir_n, 3'b100);
      if (cnt <= CW'(1)) lsr0_n = 1'b0;
    end else if (rd_go && addr == 3'd2) begin
      iir_n = 3'b001;
    end
    if (push_ex) begin
      lsr0_n = 1'b1;
      if (ier_n[0] && !iir_n[2]) begin iir_n = add_src(iir_n, 3'b100); raise = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier <= '0; iir <= 3'b001; lcr <= 8'h03; mcr <= 8'h08; scr <= '0;
      div <= 16'(DIV_INIT); lsr0 <= 1'b0;
      tx_valid <= 1'b0; tx_data <= '0; irq <= 1'b0;
    end else begin
      ier <= ier_n; iir <= iir_n; lsr0 <= lsr0_n; irq <= raise;
      tx_valid <= wr_dat && !loop;
      if (wr_dat && !loop) tx_data <= wdata;
      if (wr_en) begin
        case (addr)
          3'd0: if (dlab) div[7:0]  <= wdata;
          3'd1: if (dlab) div[15:8] <= wdata;
          3'd3: lcr <= wdata;
          3'd4: mcr <= wdata;
          3'd7: scr <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(QDEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(QDEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) q_mem[wp] <= push_byte;
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = dlab ? div[7:0] : ((cnt != '0) ? q_mem[rp] : 8'h00);
      3'd1:    rdata = dlab ? div[15:8] : {4'h0, ier};
      3'd2:    rdata = {5'b11000, iir};
      3'd3:    rdata = lcr;
      3'd4:    rdata = mcr;
      3'd5:    rdata = {1'b0, 2'b11, 4'b0000, lsr0};
      3'd6:    rdata = loop ? {mcr[3], mcr[2], mcr[0], mcr[1], MSR_BASE[3:0]} : MSR_BASE;
      default: rdata = scr;
    endcase
  end

  assert_lsr_tracks_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lsr0 == (cnt != '0));
  assert_none_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iir[0] == (iir[2:1] == 2'b00));
  assert_tx_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(wr_en && addr == 3'd0 && !lcr[7] && !mcr[4]));
  assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !iir[0]);
  assert_loop_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr[4] && cnt == FULL && wr_en && addr == 3'd0 && !lcr[7]) |=> cnt == FULL);
  assert_loop_blocks_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && mcr[4] && !wr_en && !rd_en) |=> cnt == $past(cnt));
endmodule

// File: tb/serial_reg_bank_tb_top.sv
module serial_reg_bank_tb_top;
  localparam int QD = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, src_valid = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, src_data = '0;
  logic [7:0] rdata, tx_data;
  logic tx_valid, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_reg_bank #(.QDEPTH(QD), .DIV_INIT(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_valid(src_valid), .src_data(src_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq));

  // {is_read, addr, data, expected}
  localparam int NV = 32;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1,3'd2,8'h00,8'hC1}, {1'b1,3'd3,8'h00,8'h03}, {1'b1,3'd4,8'h00,8'h08}, // R1
    {1'b1,3'd5,8'h00,8'h60}, {1'b1,3'd6,8'h00,8'hB0}, {1'b1,3'd7,8'h00,8'h00}, // R1
    {1'b1,3'd1,8'h00,8'h00}, {1'b1,3'd0,8'h00,8'h00},                          // R1
    {1'b0,3'd7,8'hA5,8'h00}, {1'b1,3'd7,8'h00,8'hA5},                          // R2
    {1'b0,3'd3,8'h83,8'h00}, {1'b1,3'd0,8'h00,8'h0C}, {1'b1,3'd1,8'h00,8'h00}, // R1 R2
    {1'b0,3'd0,8'h34,8'h00}, {1'b0,3'd1,8'h12,8'h00}, {1'b1,3'd0,8'h00,8'h34}, // R2
    {1'b1,3'd1,8'h00,8'h12}, {1'b0,3'd3,8'h03,8'h00}, {1'b1,3'd3,8'h00,8'h03}, // R2
    {1'b1,3'd1,8'h00,8'h00},                                                   // R2
    {1'b0,3'd1,8'hFF,8'h00}, {1'b1,3'd1,8'h00,8'h0F},                          // R3
    {1'b1,3'd2,8'h00,8'hC2}, {1'b1,3'd2,8'h00,8'hC1},                          // R5 R6
    {1'b0,3'd5,8'h00,8'h00}, {1'b1,3'd5,8'h00,8'h60}, {1'b0,3'd6,8'h00,8'h00}, // R12
    {1'b1,3'd6,8'h00,8'hB0}, {1'b0,3'd2,8'h55,8'h00}, {1'b1,3'd2,8'h00,8'hC1}, // R12
    {1'b0,3'd1,8'h00,8'h00}, {1'b1,3'd2,8'h00,8'hC1}                           // R5
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    #5 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); src_valid = 1; src_data = d;
    @(negedge clk); src_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    chk("R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        bus_rd(VEC[i][18:16], v);
        chk($sformatf("table vector %0d (R1/R2/R3/R5/R6/R12)", i), v, VEC[i][7:0]);
      end else bus_wr(VEC[i][18:16], VEC[i][15:8]);
    end
    // R4 transmit with and without enable
    bus_wr(3'd1, 8'h02);
    chk("R5 irq on enable change", {7'd0, irq}, 8'h01);
    bus_rd(3'd2, v);
    bus_wr(3'd0, 8'h41);
    chk("R4 tx_valid", {7'd0, tx_valid}, 8'h01);
    chk("R4 tx_data", tx_data, 8'h41);
    chk("R4 irq", {7'd0, irq}, 8'h01);
    bus_rd(3'd2, v); chk("R4 iir after tx", v, 8'hC2);
    bus_wr(3'd1, 8'h00); bus_rd(3'd2, v);
    bus_wr(3'd0, 8'h42);
    chk("R4 tx_valid no irq case", {7'd0, tx_valid}, 8'h01);
    chk("R4 irq disabled", {7'd0, irq}, 8'h00);
    bus_rd(3'd2, v); chk("R4 iir disabled", v, 8'hC1);
    // R7 R8 R9 receive path
    bus_wr(3'd1, 8'h01);
    chk("R5 no recv without data", {7'd0, irq}, 8'h00);
    push(8'h61); chk("R7 first recv irq", {7'd0, irq}, 8'h01);
    push(8'h62); chk("R7 no repeat irq", {7'd0, irq}, 8'h00);
    push(8'h63);
    bus_rd(3'd5, v); chk("R9 lsr data bit", v, 8'h61);
    bus_rd(3'd0, v); chk("R8 pop 1", v, 8'h61);
    bus_rd(3'd2, v); chk("R8 recv source removed", v, 8'hC1);
    bus_rd(3'd5, v); chk("R8 lsr still set", v, 8'h61);
    bus_rd(3'd0, v); chk("R8 pop 2", v, 8'h62);
    bus_rd(3'd0, v); chk("R8 pop 3", v, 8'h63);
    bus_rd(3'd5, v); chk("R8 lsr cleared", v, 8'h60);
    bus_rd(3'd0, v); chk("R8 empty read", v, 8'h00);
    // R5 pending data then enable
    bus_wr(3'd1, 8'h00);
    push(8'h70); chk("R7 disabled no irq", {7'd0, irq}, 8'h00);
    bus_wr(3'd1, 8'h01); chk("R5 recv irq on enable", {7'd0, irq}, 8'h01);
    bus_rd(3'd2, v); chk("R5 iir recv", v, 8'hC4);
    bus_rd(3'd0, v); chk("R8 pop pending", v, 8'h70);
    // R10 loopback
    bus_wr(3'd4, 8'h18);
    bus_wr(3'd0, 8'h11);
    chk("R10 no tx in loop", {7'd0, tx_valid}, 8'h00);
    chk("R10 recv irq in loop", {7'd0, irq}, 8'h01);
    bus_rd(3'd0, v); chk("R10 loop byte", v, 8'h11);
    push(8'h99);
    bus_rd(3'd5, v); chk("R9 source ignored in loop", v, 8'h60);
    for (int i = 0; i < QD + 2; i++) bus_wr(3'd0, 8'(i + 32));
    for (int i = 0; i < QD; i++) begin
      bus_rd(3'd0, v); chk($sformatf("R10 loop fill %0d", i), v, 8'(i + 32));
    end
    bus_rd(3'd0, v); chk("R10 cap dropped extra", v, 8'h00);
    // R11 modem status mapping
    bus_wr(3'd4, 8'h13); bus_rd(3'd6, v); chk("R11 DTR RTS", v, 8'h30);
    bus_wr(3'd4, 8'h1C); bus_rd(3'd6, v); chk("R11 OUT1 OUT2", v, 8'hC0);
    bus_wr(3'd4, 8'h10); bus_rd(3'd6, v); chk("R11 none", v, 8'h00);
    bus_wr(3'd4, 8'h08); bus_rd(3'd6, v); chk("R11 outside loop", v, 8'hB0);
    // R9 full queue drops outside bytes
    for (int i = 0; i < QD + 1; i++) push(8'(i + 128));
    for (int i = 0; i < QD; i++) begin
      bus_rd(3'd0, v); chk($sformatf("R9 fill %0d", i), v, 8'(i + 128));
    end
    bus_rd(3'd0, v); chk("R9 overflow dropped", v, 8'h00);
    bus_wr(3'd3, 8'h80); bus_rd(3'd0, v); chk("R2 divisor kept", v, 8'h34);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule